// File: doc/BRIEF.md
# Receive Ring DMA with Length Header

This block takes frames arriving as a byte stream from the MAC side and stores each one in host memory, using a ring of receive descriptors that software prepares. For every frame it fetches the next descriptor, which holds a buffer address, a buffer capacity and an end-of-table flag. It then writes the frame bytes into that buffer after a reserved header area, and finally fills the header with the stored frame length. Software hands buffers back by moving a last-descriptor offset forward. The engine never fills the descriptor that this offset names.

Two status outputs give the byte offset, relative to the ring base, of the next descriptor to be filled and of the descriptor most recently taken into use. A control bit selects what happens when no descriptor is free. With the bit clear, the stream is stalled. With it set, the frame is swallowed and dropped. A frame-count setting produces one interrupt pulse for every N stored frames. Memory writes are single bytes, each on a request/acknowledge handshake.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, inReady, descReq, memReq and rxIrq are low, and stat0Cur and stat1Active are zero.
- R2: While cfgEnable is low, inReady stays low and no descriptor fetch is requested.
- R3: The descriptor for the next frame is read at cfgRingBase + stat0Cur. In descData, bits 31:0 are the buffer address, bits 47:32 are the buffer capacity in bytes, and bit 63 is end-of-table.
- R4: Byte k of a frame is written at buffer + off + k. Here off is cfgRxOffset, except that values 0 and 1 act as 2.
- R5: After the frame data, the header is written. Buffer byte 0 holds the stored length bits 7:0, byte 1 holds bits 15:8, and bytes 2 to off-1 are zero.
- R6: Frame bytes beyond capacity - off are discarded, and the length field records the number of bytes stored. No write reaches buffer + capacity or beyond.
- R7: stat0Cur advances by 16 once a frame's header is complete. stat1Active is set to stat0Cur when a descriptor is taken and holds that value afterwards.
- R8: A frame stored in a descriptor with end-of-table set returns stat0Cur to 0.
- R9: While stat0Cur equals cfgLastDesc, no descriptor is fetched. With cfgOverflowCont low, inReady stays low until cfgLastDesc moves.
- R10: With cfgOverflowCont high and no free descriptor, a frame is accepted in full but causes no memory write. The status values do not change, and the frame does not count toward the interrupt.
- R11: rxIrq pulses for one cycle when the number of stored frames since the last pulse reaches cfgFrameCount. A setting of 1 gives one pulse per frame.
- R12: Each memory write carries one byte. memReq, memAddr and memData hold until memAck, so a frame causes exactly off + stored-length writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Engine enable |
| cfgOverflowCont | input | 1 | 1: drop frames when no descriptor is free; 0: stall |
| cfgRxOffset | input | OFF_W | Header bytes reserved at the start of each buffer |
| cfgRingBase | input | ADDR_W | Byte address of descriptor 0 |
| cfgLastDesc | input | RING_W | Ring offset of the first descriptor not yet returned |
| cfgFrameCount | input | IRQ_W | Stored frames per interrupt pulse |
| stat0Cur | output | RING_W | Ring offset of the next descriptor to fill |
| stat1Active | output | RING_W | Ring offset of the descriptor most recently taken |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte valid |
| inLast | input | 1 | Byte is the last of its frame |
| inReady | output | 1 | Engine accepts the byte |
| descReq | output | 1 | Descriptor read request |
| descAddr | output | ADDR_W | Descriptor read address |
| descAck | input | 1 | Descriptor data valid |
| descData | input | 64 | Descriptor contents |
| memReq | output | 1 | Byte write request |
| memAddr | output | ADDR_W | Byte write address |
| memData | output | 8 | Byte write data |
| memAck | input | 1 | Write accepted |
| rxIrq | output | 1 | Frame-count interrupt pulse |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit ring offsets and 16-byte descriptors. It sets up a four-entry ring with 64-byte buffers. With buffers this small, random frame lengths up to 70 bytes often exceed capacity, so truncation occurs regularly. A short ring means wrap, the stall at the last descriptor and the drop path all occur within a few frames. Header offsets are drawn from 0 to 10, which covers the clamp to 2 and headers with several zero bytes. The frame count is switched from 2 to 1 while frames are still pending toward the interrupt.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DATA,
    S_DROP,
    S_HDR,
    S_DONE
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchDesc;
    logic takeByte;
    logic hdrWrite;
  } dpCtl_t;

  localparam int DESC_W       = 64;
  localparam int DESC_EOT_BIT = 63;
  localparam int DESC_CAP_LSB = 32;
  localparam int DESC_CAP_W   = 16;
  localparam int DESC_BUF_W   = 32;
  localparam int HDR_MIN      = 2;

endpackage

// File: rtl/rx_ring_datapath.sv
module rx_ring_datapath
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DESC_W-1:0] descData,
  input  logic [7:0]        inData,
  input  logic [OFF_W-1:0]  cfgRxOffset,
  input  logic              memAck,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              memBusy,
  output logic              hdrDone,
  output logic              descEot
);

  localparam int LEN_W = DESC_CAP_W;

  logic [ADDR_W-1:0] bufAddr;
  logic [LEN_W-1:0]  capBytes;
  logic              eotFlag;
  logic [OFF_W-1:0]  offEff;
  logic [LEN_W-1:0]  lenCnt;
  logic [OFF_W-1:0]  hdrIdx;
  logic [OFF_W-1:0]  offNext;
  logic              room;
  logic [7:0]        hdrByte;

  always_comb begin
    offNext = (cfgRxOffset < OFF_W'(HDR_MIN)) ? OFF_W'(HDR_MIN) : cfgRxOffset;
    room    = (capBytes > LEN_W'(offEff)) && (lenCnt < (capBytes - LEN_W'(offEff)));
    hdrDone = (hdrIdx == offEff);
    memBusy = memReq;
    descEot = eotFlag;
    if (hdrIdx == '0)
      hdrByte = lenCnt[7:0];
    else if (hdrIdx == OFF_W'(1))
      hdrByte = lenCnt[15:8];
    else
      hdrByte = 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr  <= '0;
      capBytes <= '0;
      eotFlag  <= 1'b0;
      offEff   <= OFF_W'(HDR_MIN);
      lenCnt   <= '0;
      hdrIdx   <= '0;
      memReq   <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
    end else begin
      if (memReq && memAck) memReq <= 1'b0;
      if (ctl.latchDesc) begin
        bufAddr  <= ADDR_W'(descData[DESC_BUF_W-1:0]);
        capBytes <= descData[DESC_CAP_LSB +: DESC_CAP_W];
        eotFlag  <= descData[DESC_EOT_BIT];
        offEff   <= offNext;
        lenCnt   <= '0;
        hdrIdx   <= '0;
      end
      if (ctl.takeByte && room) begin
        memReq  <= 1'b1;
        memAddr <= bufAddr + ADDR_W'(offEff) + ADDR_W'(lenCnt);
        memData <= inData;
        lenCnt  <= lenCnt + 1'b1;
      end
      if (ctl.hdrWrite) begin
        memReq  <= 1'b1;
        memAddr <= bufAddr + ADDR_W'(hdrIdx);
        memData <= hdrByte;
        hdrIdx  <= hdrIdx + 1'b1;
      end
    end
  end

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memData));

  // R6
  write_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ((memAddr - bufAddr) < ADDR_W'(capBytes)));

endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RING_W     = 16,
  parameter int IRQ_W      = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgOverflowCont,
  input  logic [ADDR_W-1:0] cfgRingBase,
  input  logic [RING_W-1:0] cfgLastDesc,
  input  logic [IRQ_W-1:0]  cfgFrameCount,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              descReq,
  output logic [ADDR_W-1:0] descAddr,
  input  logic              descAck,
  input  logic              memBusy,
  input  logic              hdrDone,
  input  logic              descEot,
  output dpCtl_t            ctl,
  output logic [RING_W-1:0] stat0Cur,
  output logic [RING_W-1:0] stat1Active,
  output logic              rxIrq
);

  localparam logic [RING_W-1:0] STEP = RING_W'(DESC_BYTES);

  rxState_t         state;
  logic [RING_W-1:0] curOfs;
  logic [RING_W-1:0] activeOfs;
  logic [IRQ_W-1:0]  frameCnt;
  logic              irqQ;
  logic              haveDesc;
  logic              beat;
  logic              irqHit;

  always_comb begin
    haveDesc = (curOfs != cfgLastDesc);
    inReady  = cfgEnable && (((state == S_DATA) && !memBusy) || (state == S_DROP));
    descReq  = (state == S_FETCH);
    descAddr = cfgRingBase + ADDR_W'(curOfs);
    beat     = inValid && inReady;
    irqHit   = (({1'b0, frameCnt} + 1'b1) >= {1'b0, cfgFrameCount});
    ctl           = '0;
    ctl.latchDesc = (state == S_FETCH) && descAck;
    ctl.takeByte  = (state == S_DATA) && beat;
    ctl.hdrWrite  = (state == S_HDR) && !memBusy && !hdrDone;
  end

  assign stat0Cur    = curOfs;
  assign stat1Active = activeOfs;
  assign rxIrq       = irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      curOfs    <= '0;
      activeOfs <= '0;
      frameCnt  <= '0;
      irqQ      <= 1'b0;
    end else begin
      irqQ <= 1'b0;
      unique case (state)
        S_IDLE: if (cfgEnable && inValid) begin
          if (haveDesc) begin
            state     <= S_FETCH;
            activeOfs <= curOfs;
          end else if (cfgOverflowCont) begin
            state <= S_DROP;
          end
        end
        S_FETCH: if (descAck) state <= S_DATA;
        S_DATA:  if (beat && inLast) state <= S_HDR;
        S_DROP:  if (beat && inLast) state <= S_IDLE;
        S_HDR:   if (!memBusy && hdrDone) state <= S_DONE;
        S_DONE: begin
          curOfs <= descEot ? '0 : curOfs + STEP;
          if (irqHit) begin
            irqQ     <= 1'b1;
            frameCnt <= '0;
          end else begin
            frameCnt <= frameCnt + 1'b1;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stat0Cur) |-> (stat0Cur == '0) || (stat0Cur == $past(stat0Cur) + STEP));

  // R9
  fetch_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(descReq) |-> (descAddr != cfgRingBase + ADDR_W'(cfgLastDesc)));

  // R10
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DROP) |-> !memBusy);

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RING_W     = 16,
  parameter int OFF_W      = 8,
  parameter int IRQ_W      = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgOverflowCont,
  input  logic [OFF_W-1:0]  cfgRxOffset,
  input  logic [ADDR_W-1:0] cfgRingBase,
  input  logic [RING_W-1:0] cfgLastDesc,
  input  logic [IRQ_W-1:0]  cfgFrameCount,
  output logic [RING_W-1:0] stat0Cur,
  output logic [RING_W-1:0] stat1Active,
  input  logic [7:0]        inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              descReq,
  output logic [ADDR_W-1:0] descAddr,
  input  logic              descAck,
  input  logic [DESC_W-1:0] descData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  input  logic              memAck,
  output logic              rxIrq
);

  dpCtl_t ctl;
  logic   memBusy;
  logic   hdrDone;
  logic   descEot;

  rx_ring_ctrl #(
    .ADDR_W(ADDR_W), .RING_W(RING_W), .IRQ_W(IRQ_W), .DESC_BYTES(DESC_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgEnable(cfgEnable), .cfgOverflowCont(cfgOverflowCont),
    .cfgRingBase(cfgRingBase), .cfgLastDesc(cfgLastDesc),
    .cfgFrameCount(cfgFrameCount),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .descReq(descReq), .descAddr(descAddr), .descAck(descAck),
    .memBusy(memBusy), .hdrDone(hdrDone), .descEot(descEot),
    .ctl(ctl), .stat0Cur(stat0Cur), .stat1Active(stat1Active), .rxIrq(rxIrq)
  );

  rx_ring_datapath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .descData(descData),
    .inData(inData), .cfgRxOffset(cfgRxOffset), .memAck(memAck),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memBusy(memBusy), .hdrDone(hdrDone), .descEot(descEot)
  );

endmodule

// File: tb/rx_ring_dma_bench.sv
module rx_ring_dma_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic        cfgOverflowCont = 1'b0;
  logic [7:0]  cfgRxOffset = 8'd6;
  logic [31:0] cfgRingBase = 32'h100;
  logic [15:0] cfgLastDesc = 16'h30;
  logic [7:0]  cfgFrameCount = 8'd2;
  logic [15:0] stat0Cur, stat1Active;
  logic [7:0]  inData = 8'h00;
  logic        inValid = 1'b0, inLast = 1'b0, inReady;
  logic        descReq, descAck = 1'b0;
  logic [31:0] descAddr;
  logic [63:0] descData = '0;
  logic        memReq, memAck = 1'b0;
  logic [31:0] memAddr;
  logic [7:0]  memData;
  logic        rxIrq;

  always #10 clk = ~clk;

  rx_ring_dma u_rx_ring_dma (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgOverflowCont(cfgOverflowCont),
    .cfgRxOffset(cfgRxOffset), .cfgRingBase(cfgRingBase), .cfgLastDesc(cfgLastDesc),
    .cfgFrameCount(cfgFrameCount), .stat0Cur(stat0Cur), .stat1Active(stat1Active),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .descReq(descReq), .descAddr(descAddr), .descAck(descAck), .descData(descData),
    .memReq(memReq), .memAddr(memAddr), .memData(memData), .memAck(memAck),
    .rxIrq(rxIrq)
  );

  logic [7:0]  mem [0:4095];
  logic [63:0] descTab [0:3];
  logic [7:0]  fb [0:127];
  int checks = 0, errors = 0, writes = 0, irqs = 0, fetches = 0, cycles = 0;
  logic [31:0] lastFetch = '0;
  int curModel = 0, pend = 0, expIrq = 0;

  // memory and descriptor models
  always @(negedge clk) begin
    if (memReq && !memAck && ($urandom % 4 != 0)) begin
      memAck = 1'b1;
      mem[memAddr[11:0]] = memData;
    end else memAck = 1'b0;
    if (descReq && !descAck && ($urandom % 3 != 0)) begin
      descAck = 1'b1;
      descData = descTab[(descAddr - 32'h100) >> 4 & 32'd3];
      lastFetch = descAddr;
    end else descAck = 1'b0;
  end

  always @(posedge clk) begin
    cycles++;
    if (memReq && memAck) writes++;
    if (rxIrq) irqs++;
    if ($rose(descReq)) fetches++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendFrame(int len);
    logic hs;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inData = fb[i]; inValid = 1'b1; inLast = (i == len - 1);
      do begin
        #1 hs = inReady;
        @(posedge clk);
      end while (!hs);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  function automatic int nextOfs(int ofs);
    return (ofs == 48) ? 0 : ofs + 16;
  endfunction

  task automatic doFrame(int len, int off);
    int idx, offE, stored, base, w0, prev, nxt, bad, zbad, n;
    @(negedge clk);
    cfgRxOffset = 8'(off);
    idx = curModel / 16;
    base = 32'h400 + idx * 256;
    for (int j = 0; j < 256; j++) mem[base + j] = 8'hEE;
    for (int j = 0; j < len; j++) fb[j] = 8'($urandom);
    offE = (off < 2) ? 2 : off;
    stored = (len < 64 - offE) ? len : 64 - offE;
    w0 = writes; prev = curModel; nxt = nextOfs(curModel);
    sendFrame(len);
    n = 0;
    while (stat0Cur !== 16'(nxt) && n < 3000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk("R7 stat0", stat0Cur, nxt);
    chk("R7 stat1", stat1Active, prev);
    chk("R3 fetch addr", lastFetch, 32'h100 + prev);
    chk("R5 len lo", mem[base], stored & 8'hFF);
    chk("R5 len hi", mem[base + 1], (stored >> 8) & 8'hFF);
    zbad = 0;
    for (int j = 2; j < offE; j++) if (mem[base + j] !== 8'h00) zbad++;
    chk("R5 zero header", zbad, 0);
    bad = 0;
    for (int j = 0; j < stored; j++) if (mem[base + offE + j] !== fb[j]) bad++;
    chk("R4 data", bad, 0);
    if (stored < 64 - offE) chk("R4 end sentinel", mem[base + offE + stored], 8'hEE);
    else chk("R6 cap sentinel", mem[base + 64], 8'hEE);
    chk("R12 write count", writes - w0, offE + stored);
    pend++;
    if (pend >= cfgFrameCount) begin expIrq++; pend = 0; end
    chk("R11 irq count", irqs, expIrq);
    curModel = nxt;
  endtask

  initial begin
    int rdy, f0, w0, i0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++)
      descTab[i] = {(i == 3), 15'd0, 16'd64, 32'h400 + 32'(i) * 32'd256};
    for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 inReady", inReady, 0);
    chk("R1 descReq", descReq, 0);
    chk("R1 memReq", memReq, 0);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 stat0", stat0Cur, 0);
    chk("R1 stat1", stat1Active, 0);

    // R2 disabled engine ignores a waiting frame
    inValid = 1'b1; inLast = 1'b0; rdy = 0;
    repeat (20) begin @(negedge clk); if (inReady) rdy++; end
    chk("R2 ready while disabled", rdy, 0);
    chk("R2 no fetch while disabled", fetches, 0);
    cfgEnable = 1'b1;

    doFrame(1 + $urandom % 50, 6);
    doFrame(70, 6);                 // R6 truncation: 58 bytes stored
    doFrame(1 + $urandom % 50, 6);

    // R9 stall: stat0 == last descriptor, overflow-continue off
    @(negedge clk);
    inValid = 1'b1; inLast = 1'b0; rdy = 0; f0 = fetches;
    repeat (30) begin @(negedge clk); if (inReady) rdy++; end
    chk("R9 stalled ready", rdy, 0);
    chk("R9 no fetch", fetches - f0, 0);
    chk("R9 stat0 held", stat0Cur, 16'h30);
    cfgLastDesc = 16'h10;
    doFrame(20, 6);
    chk("R8 wrap", stat0Cur, 0);
    doFrame(1 + $urandom % 40, 1);  // R4 offset 1 acts as 2

    // R10 drop with overflow-continue
    @(negedge clk);
    cfgOverflowCont = 1'b1;
    w0 = writes; i0 = irqs; f0 = fetches;
    for (int j = 0; j < 15; j++) fb[j] = 8'($urandom);
    sendFrame(15);
    repeat (10) @(negedge clk);
    chk("R10 no writes", writes - w0, 0);
    chk("R10 stat0", stat0Cur, 16'h10);
    chk("R10 stat1", stat1Active, 0);
    chk("R10 no irq", irqs - i0, 0);
    chk("R10 no fetch", fetches - f0, 0);
    cfgOverflowCont = 1'b0;

    // R11 one pulse per frame, random traffic
    cfgFrameCount = 8'd1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cfgLastDesc = 16'(nextOfs(curModel));
      doFrame(1 + $urandom % 70, $urandom % 11);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule